// File: doc/BRIEF.md
# Card Presence Debounce and Interrupt Controller

This block sits between a smart-card connector's presence contact and the host. It qualifies a card insertion with a cycle-counted debounce window, reports a removal at once, and drives a single active-low interrupt line. While no card session is open, that line also serves as plain presence status: high means a qualified card is seated, low means none.

When the host opens a session by pulling its session-enable level low, the block watches three digital fault flags: card supply overload, overtemperature and host-supply undervoltage. It also treats loss of the card as a fault. The first fault in a session pulls the interrupt line low and raises a one-cycle deactivation request for the activation sequencer. The fault is then held until the host closes the session and the sequencer reports that it is no longer busy.

The presence contact polarity is set by a strap, so both normally-open and normally-closed connectors are supported. The raw contact first passes through a synchronizer of `SYNC_STAGES` flops (default 2), and only then reaches the debounce counter.

Top module: `card_presence_irq`

## Requirements
- R1: With `pres_hi_sel` = 1 the contact reads present when `pres_raw` = 1. With `pres_hi_sel` = 0 it reads present when `pres_raw` = 0.
- R2: Take the default 2-stage synchronizer, the block idle and all flags low. If the contact reads present at `DEB_CYCLES`+1 consecutive rising edges ending at edge k, `irq_n` goes high at edge k+2 and not before.
- R3: A single edge at which the contact reads absent restarts the debounce count, so a full new window is needed.
- R4: When the contact stops reading present at edge k, `irq_n` is low after edge k+2 with no debounce wait.
- R5: While no fault is held and no flag is set, `irq_n` is high exactly when a qualified card is present. This holds both idle (`sess_en_n` = 1) and in a session.
- R6: In a session (`sess_en_n` = 0), any of the following, seen at an edge, drives `irq_n` low at that edge: `ovl_flag`, `otp_flag`, `uv_flag`, or loss of the qualified card. If no fault was held, `deact_req` is also high for exactly that one cycle.
- R7: A fault latched in a session keeps `irq_n` low until an edge with `sess_en_n` = 1 and `seq_busy` = 0. After that edge `irq_n` follows presence again.
- R8: `uv_flag` = 1 forces `irq_n` low at the next edge, whether a session is open or not. When `uv_flag` returns low while idle with the card still qualified, `irq_n` returns high at the next edge.
- R9: During and after reset, `irq_n` is low and `deact_req` is low until an insertion has been debounced.
- R10: While idle, `ovl_flag` and `otp_flag` are ignored: `irq_n` keeps following presence and `deact_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pres_raw | input | 1 | Raw card presence contact |
| pres_hi_sel | input | 1 | Contact polarity strap: 1 means present when high |
| sess_en_n | input | 1 | Host session enable, low opens a session |
| uv_flag | input | 1 | Host supply below undervoltage threshold (hysteresis already applied) |
| ovl_flag | input | 1 | Card supply overload |
| otp_flag | input | 1 | Overtemperature |
| seq_busy | input | 1 | Deactivation sequence still running |
| irq_n | output | 1 | Interrupt and presence status, active low |
| deact_req | output | 1 | One-cycle request for automatic deactivation |

## Verification
The bench aims at the exact edge on which a debounced insertion raises the interrupt. A counter that is off by one would raise it one cycle early or late. It also sends a one-cycle bounce in the middle of the window: a design that only pauses the count would report the card too early. Removal is timed against the synchronizer depth, and a design that debounced removals would keep the line high for a whole window. The latched fault is released while the sequencer is still busy and again after it has finished. This catches a design that clears the fault as soon as the session closes, and one that repeats the deactivation pulse. Flags raised while idle confirm that only the undervoltage flag affects the line outside a session.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

  // Sources that can end a card session; any set bit is a fault.
  typedef struct packed {
    logic undervolt;
    logic overload;
    logic overtemp;
    logic card_gone;
  } fault_vec_t;

  // Map the raw contact level to "card seated" for the strapped polarity.
  function automatic logic contact_active(input logic raw, input logic active_high);
    return active_high ? raw : ~raw;
  endfunction

  // True on the last counted cycle of a debounce window of 'limit' cycles.
  function automatic logic window_full(input int unsigned count, input int unsigned limit);
    return (count + 1) == limit;
  endfunction

  // Any fault source set.
  function automatic logic any_fault(input fault_vec_t f);
    return f.undervolt | f.overload | f.overtemp | f.card_gone;
  endfunction

endpackage

// File: rtl/cpi_sync.sv
module cpi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cpi_debounce.sv
module cpi_debounce #(
  parameter int unsigned LIMIT = 216000,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  output logic qualified,
  output logic restart
);
  logic [CNT_W-1:0] cnt;
  logic             last_tick;

  // Internal events exposed for the assertions.
  assign restart   = ~present;
  assign last_tick = cpi_pkg::window_full(32'(cnt), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      qualified <= 1'b0;
    end else if (restart) begin
      cnt       <= '0;
      qualified <= 1'b0;
    end else if (!qualified) begin
      if (last_tick) qualified <= 1'b1;
      else           cnt       <= cnt + 1'b1;
    end
  end

  // R3
  absent_clears_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !present |=> !qualified);

  // R2
  qual_rise_needs_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qualified) |-> $past(present));

endmodule

// File: rtl/cpi_fault_ctrl.sv
module cpi_fault_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic card_ok,
  input  logic session,
  input  logic uv,
  input  logic ovl,
  input  logic otp,
  input  logic seq_busy,
  output logic irq_n,
  output logic deact_req
);
  import cpi_pkg::*;

  fault_vec_t src;
  logic       fault_event;
  logic       fresh_fault;
  logic       latch_clear;
  logic       fault_lat;
  logic       irq_next;

  assign src.undervolt = uv;
  assign src.overload  = ovl;
  assign src.overtemp  = otp;
  assign src.card_gone = ~card_ok;

  assign fault_event = session & any_fault(src);
  assign fresh_fault = fault_event & ~fault_lat;
  assign latch_clear = ~session & ~seq_busy;
  assign irq_next    = card_ok & ~uv & ~fault_event & ~fault_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_lat <= 1'b0;
    end else if (fault_event) begin
      fault_lat <= 1'b1;
    end else if (latch_clear) begin
      fault_lat <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n     <= 1'b0;
      deact_req <= 1'b0;
    end else begin
      irq_n     <= irq_next;
      deact_req <= fresh_fault;
    end
  end

  // R6
  session_flag_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (session && (ovl || otp)) |=> !irq_n);

  // R6
  deact_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |=> !deact_req);

  // R7
  fault_held_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_lat && session) |=> (fault_lat && !irq_n));

  // R8
  uv_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> !irq_n);

  // R10
  no_deact_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !session |=> !deact_req);

endmodule

// File: rtl/card_presence_irq.sv
module card_presence_irq #(
  parameter int unsigned DEB_CYCLES  = 216000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pres_raw,
  input  logic pres_hi_sel,
  input  logic sess_en_n,
  input  logic uv_flag,
  input  logic ovl_flag,
  input  logic otp_flag,
  input  logic seq_busy,
  output logic irq_n,
  output logic deact_req
);
  logic seated_raw;
  logic present_s;
  logic qualified;
  logic deb_restart;
  logic card_ok;
  logic session;

  // Polarity applied before the synchronizer so reset means "absent".
  assign seated_raw = cpi_pkg::contact_active(pres_raw, pres_hi_sel);
  assign session    = ~sess_en_n;

  cpi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (seated_raw),
    .q     (present_s)
  );

  cpi_debounce #(.LIMIT(DEB_CYCLES)) u_deb (
    .clk       (clk),
    .rst_n     (rst_n),
    .present   (present_s),
    .qualified (qualified),
    .restart   (deb_restart)
  );

  // Removal bypasses the debounce: card_ok falls with the synchronized contact.
  assign card_ok = present_s & qualified;

  cpi_fault_ctrl u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .card_ok   (card_ok),
    .session   (session),
    .uv        (uv_flag),
    .ovl       (ovl_flag),
    .otp       (otp_flag),
    .seq_busy  (seq_busy),
    .irq_n     (irq_n),
    .deact_req (deact_req)
  );

  // R4
  card_gone_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deb_restart |=> !irq_n);

  // R5
  irq_high_means_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n |-> $past(card_ok));

endmodule

// File: tb/test_card_presence_irq.sv
`timescale 1ns/1ps
module test_card_presence_irq;
  localparam int unsigned DEB = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pres_raw = 1'b1;
  logic pres_hi_sel = 1'b0;
  logic sess_en_n = 1'b1;
  logic uv_flag = 1'b0;
  logic ovl_flag = 1'b0;
  logic otp_flag = 1'b0;
  logic seq_busy = 1'b0;
  logic irq_n;
  logic deact_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  bit run_cmp = 0;
  string phase = "R9";

  always #2.5 clk = ~clk;

  card_presence_irq #(.DEB_CYCLES(DEB), .SYNC_STAGES(2)) i_card_presence_irq (
    .clk(clk), .rst_n(rst_n), .pres_raw(pres_raw), .pres_hi_sel(pres_hi_sel),
    .sess_en_n(sess_en_n), .uv_flag(uv_flag), .ovl_flag(ovl_flag),
    .otp_flag(otp_flag), .seq_busy(seq_busy), .irq_n(irq_n), .deact_req(deact_req)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Seated per strap (R1).
  function automatic bit seated(input logic raw, input logic hi);
    return hi ? (raw == 1'b1) : (raw == 1'b0);
  endfunction

  // Reference model built from the requirements: run length of seated samples.
  int  m_run, m_run_d;
  bit  m_lat;
  logic exp_irq_n, exp_deact;

  always @(posedge clk or negedge rst_n) begin
    bit card, sess, bad;
    if (!rst_n) begin
      m_run <= 0; m_run_d <= 0; m_lat <= 0;
      exp_irq_n <= 1'b0; exp_deact <= 1'b0;
    end else begin
      card = (m_run_d >= int'(DEB) + 1);
      sess = !sess_en_n;
      bad  = sess && (uv_flag || ovl_flag || otp_flag || !card);
      m_run   <= seated(pres_raw, pres_hi_sel) ? ((m_run < 1000) ? m_run + 1 : m_run) : 0;
      m_run_d <= m_run;
      exp_deact <= bad && !m_lat;
      exp_irq_n <= card && !uv_flag && !bad && !m_lat;
      if (bad) m_lat <= 1'b1;
      else if (!sess && !seq_busy) m_lat <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      check(phase, irq_n, exp_irq_n);
      check(phase, deact_req, exp_deact);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    cyc(3);
    check("R9", irq_n, 1'b0);
    check("R9", deact_req, 1'b0);
    rst_n = 1'b1;
    run_cmp = 1;
    cyc(10);
    check("R9", irq_n, 1'b0);

    // Insertion, active-low contact: exact rise edge (R1, R2).
    phase = "R2";
    pres_raw = 1'b0;
    cyc(DEB + 2);
    check("R2", irq_n, 1'b0);
    cyc(1);
    check("R1", irq_n, 1'b1);
    cyc(5);

    // Removal is immediate (R4).
    phase = "R4";
    pres_raw = 1'b1;
    cyc(2);
    check("R4", irq_n, 1'b1);
    cyc(1);
    check("R4", irq_n, 1'b0);
    cyc(5);

    // Bounce restarts the window (R3).
    phase = "R3";
    pres_raw = 1'b0;
    cyc(10);
    pres_raw = 1'b1;
    cyc(1);
    pres_raw = 1'b0;
    cyc(DEB + 2);
    check("R3", irq_n, 1'b0);
    cyc(1);
    check("R3", irq_n, 1'b1);
    cyc(3);

    // Active-high strap: low level now means absent (R1).
    phase = "R1";
    pres_hi_sel = 1'b1;
    pres_raw = 1'b0;
    cyc(4);
    check("R1", irq_n, 1'b0);
    pres_raw = 1'b1;
    cyc(DEB + 3);
    check("R1", irq_n, 1'b1);

    // Undervoltage while idle (R8).
    phase = "R8";
    uv_flag = 1'b1;
    cyc(1);
    check("R8", irq_n, 1'b0);
    cyc(3);
    uv_flag = 1'b0;
    cyc(1);
    check("R8", irq_n, 1'b1);

    // Idle flags ignored (R10).
    phase = "R10";
    ovl_flag = 1'b1; otp_flag = 1'b1;
    cyc(4);
    check("R10", irq_n, 1'b1);
    check("R10", deact_req, 1'b0);
    ovl_flag = 1'b0; otp_flag = 1'b0;
    cyc(2);

    // Session without fault keeps status (R5), then overload (R6) and latch (R7).
    phase = "R5";
    sess_en_n = 1'b0;
    cyc(5);
    check("R5", irq_n, 1'b1);
    phase = "R6";
    ovl_flag = 1'b1;
    cyc(1);
    check("R6", irq_n, 1'b0);
    check("R6", deact_req, 1'b1);
    ovl_flag = 1'b0;
    cyc(1);
    check("R6", deact_req, 1'b0);
    phase = "R7";
    cyc(4);
    check("R7", irq_n, 1'b0);
    seq_busy = 1'b1;
    sess_en_n = 1'b1;
    cyc(4);
    check("R7", irq_n, 1'b0);
    seq_busy = 1'b0;
    cyc(1);
    check("R7", irq_n, 1'b0);
    cyc(1);
    check("R7", irq_n, 1'b1);

    // Removal during a session raises deactivation (R6).
    phase = "R6";
    sess_en_n = 1'b0;
    cyc(3);
    pres_raw = 1'b0;
    cyc(3);
    check("R6", deact_req, 1'b1);
    check("R6", irq_n, 1'b0);
    sess_en_n = 1'b1;
    cyc(4);

    // Random mix against the model.
    phase = "R5";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 59) == 0) pres_raw = ~pres_raw;
      if ($urandom_range(0, 299) == 0) sess_en_n = ~sess_en_n;
      uv_flag  = ($urandom_range(0, 99) == 0);
      ovl_flag = ($urandom_range(0, 149) == 0);
      otp_flag = ($urandom_range(0, 199) == 0);
      seq_busy = ($urandom_range(0, 3) == 0);
      cyc(1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule